// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with Watchdog Mode

This block is a general-purpose timer built around a 16-bit down counter. The counter is clocked by an 8-bit programmable prescaler or, in one mode, by edges on an external input. Software reaches five byte-wide registers through a simple synchronous write port and a combinational read port: two reload bytes, the prescaler divisor, a control byte and a watchdog-mode byte. Whenever the counter steps while at zero it signals end of count. It then either reloads and keeps going or stops, depending on the run mode. End of count drives a one-cycle pulse, an interrupt request and a general-purpose output pin whose behaviour the control byte selects.

Four input modes decide how the external input shapes counting. In event mode the input's rising edges decrement the counter. In gated mode the input's level enables the counter. In triggered mode an edge starts an idle counter. In retriggered mode every edge reloads the counter. Setting the watchdog bit locks the block into free-running operation. Software must then rewrite the low reload byte before the count runs out; otherwise end of count becomes a reset request instead of an interrupt. The input is taken to be synchronous to `clk`.

Top module: `prescaled_wdog_timer`

## Requirements
- R1: After reset, reads return FFh at addresses 0, 1 and 2, 12h at address 3 and 00h at address 4. The output pin is 1, and `eoc_o`, `irq_o` and `rst_req_o` are 0.
- R2: The register map is as follows. Address 0 holds reload bits 15:8 and address 1 holds reload bits 7:0. Address 2 is the prescaler value N. Address 3 is control, laid out as bit 7 run, bit 6 single (1) or continuous (0), bits 5:4 input mode (00 event, 01 gated, 10 triggered, 11 retriggered), bit 3 input enable, bit 2 output toggle (1) or pulse (0), bit 1 output level and bit 0 output enable. Bit 0 of address 4 is the watchdog enable. Written values of addresses 2 and 3 read back unchanged while stopped.
- R3: A write that sets run while stopped loads the counter from the reload value. With the input ignored, the first `eoc_o` pulse is visible (R+1)·(N+1) cycles after that write edge, where R is the reload value.
- R4: In continuous mode, end of count reloads the counter and `eoc_o` repeats every (R+1)·(N+1) cycles. In single mode, exactly one pulse occurs and control bit 7 then reads 0.
- R5: Reads of addresses 0 and 1 return the live counter. Writing a reload byte while running does not change the counter in timer mode.
- R6: Writing run = 0 freezes the counter after the step taken at that write's edge.
- R7: With input enable at 0, the external input is ignored and the counter steps on every prescaler tick, whatever the input mode.
- R8: In event mode, each rising edge of `ext_in` decrements the counter once, independent of the prescaler. A level held high counts once.
- R9: In gated mode, prescaler ticks step the counter only in cycles where `ext_in` is 1.
- R10: In triggered mode, a start leaves the counter idle at the reload value. A rising edge reloads it and starts counting, and edges while counting are ignored.
- R11: In retriggered mode, every rising edge reloads the counter, including while it is counting.
- R12: With output enable at 0 the pin equals the output-level bit. With output enable at 1 and toggle mode, the pin starts from the level last held and inverts at each end of count. In pulse mode the pin equals `eoc_o`.
- R13: Outside watchdog mode, `irq_o` pulses together with `eoc_o` and `rst_req_o` stays 0.
- R14: Once set, the watchdog enable ignores writes of 0 until reset. It forces run (control bit 7 reads 1), counts prescaler ticks continuously whatever the input mode, and reloads the counter on every write to address 1. End of count then pulses `rst_req_o` and not `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ext_in | input | 1 | External count/gate/trigger input |
| eoc_o | output | 1 | One-cycle end-of-count pulse |
| irq_o | output | 1 | Interrupt request pulse (timer mode) |
| rst_req_o | output | 1 | Reset request pulse (watchdog mode) |
| tmr_out_o | output | 1 | General-purpose timer output pin |

## Verification
A wrong counter state shows at the read port in the very next cycle, because addresses 0 and 1 return the live count. The bench therefore reads the count right after each stimulus, instead of waiting for end of count. Prescaler or reload faults shift the first `eoc_o` pulse, and the bench checks that pulse on every cycle of the period, so an error of a single cycle is caught. Input-mode faults change the count left after a known number of edges, which separates triggered from retriggered behaviour within two pulses. A watchdog state that is lost or released shows as a missing or early `rst_req_o` pulse, or as control bit 7 reading 0.

// File: rtl/pwt_pkg.sv
// Shared types and constants for the prescaled timer/watchdog.
// Assumes a byte-wide register port; the counter is two register bytes wide.
package pwt_pkg;
    localparam int REG_W = 8;
    localparam int CNT_W = 2 * REG_W;

    localparam int A_CNT_HI = 0;
    localparam int A_CNT_LO = 1;
    localparam int A_PRE    = 2;
    localparam int A_CTRL   = 3;
    localparam int A_WDOG   = 4;

    typedef enum logic [1:0] {
        IN_EVENT  = 2'b00,
        IN_GATED  = 2'b01,
        IN_TRIG   = 2'b10,
        IN_RETRIG = 2'b11
    } in_mode_e;

    typedef struct packed {
        logic     run;
        logic     single;
        in_mode_e mode;
        logic     in_en;
        logic     out_toggle;
        logic     out_level;
        logic     out_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = ctrl_t'(8'h12);
endpackage

// File: rtl/pwt_prescaler.sv
// Programmable divider: emits one tick every DIV+1 enabled cycles.
// Assumes restart has priority and reloads the divider so the first
// tick after restart comes DIV+1 enabled cycles later.
module pwt_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         en,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] pcnt;

    assign tick = en && (pcnt == '0) && !restart;

    // Down-count the divider and reload at terminal count or restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '1;
        end else if (restart) begin
            pcnt <= div;
        end else if (en) begin
            if (pcnt == '0) pcnt <= div;
            else            pcnt <= pcnt - W'(1);
        end
    end
endmodule

// File: rtl/pwt_regs.sv
// Register file: reload bytes, prescaler, control and sticky watchdog bit.
// Produces the load request for starts and watchdog refreshes and the
// combinational read mux (counter reads return the live count).
module pwt_regs
    import pwt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              single_done,
    output logic [REG_W-1:0]  rdata,
    output logic              run_eff,
    output logic              wd_en,
    output logic              ctrl_single,
    output in_mode_e          ctrl_mode,
    output logic              ctrl_in_en,
    output logic              out_toggle,
    output logic              out_level,
    output logic              out_en,
    output logic [REG_W-1:0]  pre_val,
    output logic [CNT_W-1:0]  reload_nxt,
    output logic              load_req,
    output logic              load_arm
);
    ctrl_t            ctrl_q;
    ctrl_t            ctrl_new;
    ctrl_t            ctrl_rd;
    logic [CNT_W-1:0] reload_q;
    logic             wr_hi, wr_lo, wr_pre, wr_ctrl, wr_wd;
    logic             start_wr, wd_on, wd_kick;

    assign wr_hi   = wr_en && (addr == ADDR_W'(A_CNT_HI));
    assign wr_lo   = wr_en && (addr == ADDR_W'(A_CNT_LO));
    assign wr_pre  = wr_en && (addr == ADDR_W'(A_PRE));
    assign wr_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
    assign wr_wd   = wr_en && (addr == ADDR_W'(A_WDOG));
    assign ctrl_new = ctrl_t'(wdata);

    assign run_eff     = ctrl_q.run || wd_en;
    assign ctrl_single = ctrl_q.single;
    assign ctrl_mode   = ctrl_q.mode;
    assign ctrl_in_en  = ctrl_q.in_en;
    assign out_toggle  = ctrl_q.out_toggle;
    assign out_level   = ctrl_q.out_level;
    assign out_en      = ctrl_q.out_en;

    // Reload value including a write landing this cycle.
    assign reload_nxt = {wr_hi ? wdata : reload_q[CNT_W-1:REG_W],
                         wr_lo ? wdata : reload_q[REG_W-1:0]};

    // Load on a stopped-to-running transition or a watchdog refresh.
    assign start_wr = wr_ctrl && ctrl_new.run && !run_eff;
    assign wd_on    = wr_wd && wdata[0] && !run_eff;
    assign wd_kick  = wr_lo && wd_en;
    assign load_req = start_wr || wd_on || wd_kick;
    assign load_arm = start_wr && ctrl_new.in_en && ctrl_new.mode[1];

    // Hold the reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) reload_q <= '1;
        else        reload_q <= reload_nxt;
    end

    // Hold the prescaler divisor.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_val <= '1;
        else if (wr_pre) pre_val <= wdata;
    end

    // Hold control; single-mode completion drops the run bit.
    always_ff @(posedge clk) begin
        if (!rst_n)           ctrl_q <= CTRL_RST;
        else if (wr_ctrl)     ctrl_q <= ctrl_new;
        else if (single_done) ctrl_q.run <= 1'b0;
    end

    // Sticky watchdog enable: only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  wd_en <= 1'b0;
        else if (wr_wd && wdata[0])  wd_en <= 1'b1;
    end

    // Read mux; control reads show the effective run state.
    always_comb begin
        ctrl_rd     = ctrl_q;
        ctrl_rd.run = run_eff;
        unique case (addr)
            ADDR_W'(A_CNT_HI): rdata = cnt_val[CNT_W-1:REG_W];
            ADDR_W'(A_CNT_LO): rdata = cnt_val[REG_W-1:0];
            ADDR_W'(A_PRE):    rdata = pre_val;
            ADDR_W'(A_CTRL):   rdata = REG_W'(ctrl_rd);
            ADDR_W'(A_WDOG):   rdata = {{(REG_W-1){1'b0}}, wd_en};
            default:           rdata = '0;
        endcase
    end
endmodule

// File: rtl/pwt_counter.sv
// Main down counter with input-mode logic.
// Assumes ext_in is synchronous to clk. A step taken at zero is end of
// count: the counter reloads and, in single mode, goes idle.
module pwt_counter
    import pwt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_eff,
    input  logic             wd_en,
    input  logic             in_en,
    input  logic             single,
    input  in_mode_e         mode,
    input  logic             ext_in,
    input  logic             tick,
    input  logic             load_req,
    input  logic             load_arm,
    input  logic [CNT_W-1:0] reload_nxt,
    output logic [CNT_W-1:0] cnt,
    output logic             pre_en,
    output logic             pre_restart,
    output logic             wrap,
    output logic             single_done,
    output logic             eoc
);
    logic ext_q;
    logic active;
    logic use_in;
    logic in_edge;
    logic trig;
    logic step_raw;
    logic step_ok;

    assign use_in  = in_en && !wd_en;
    assign in_edge = ext_in && !ext_q;
    assign trig    = run_eff && !load_req && use_in && mode[1] && in_edge &&
                     (!active || mode == IN_RETRIG);

    // Select the step source for the active input mode.
    always_comb begin
        if (!active || !run_eff) begin
            step_raw = 1'b0;
        end else if (!use_in) begin
            step_raw = tick;
        end else begin
            unique case (mode)
                IN_EVENT: step_raw = in_edge;
                IN_GATED: step_raw = tick && ext_in;
                default:  step_raw = tick;
            endcase
        end
    end

    assign step_ok     = step_raw && !load_req && !trig;
    assign wrap        = step_ok && (cnt == '0);
    assign single_done = wrap && single && !wd_en;
    assign pre_en      = active && run_eff;
    assign pre_restart = load_req || trig;

    // Remember the input level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_in;
    end

    // Register the end-of-count pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) eoc <= 1'b0;
        else        eoc <= wrap;
    end

    // Counter and activity state: load, stop, trigger, then step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '1;
            active <= 1'b0;
        end else if (load_req) begin
            cnt    <= reload_nxt;
            active <= !load_arm;
        end else if (!run_eff) begin
            active <= 1'b0;
        end else if (trig) begin
            cnt    <= reload_nxt;
            active <= 1'b1;
        end else if (step_ok) begin
            if (cnt == '0) begin
                cnt <= reload_nxt;
                if (single_done) active <= 1'b0;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/pwt_outpin.sv
// Output pin: fixed level when disabled, otherwise a toggle or pulse.
// Assumes the toggle state tracks the fixed level while disabled so
// enabling starts from the level last driven.
module pwt_outpin (
    input  logic clk,
    input  logic rst_n,
    input  logic out_en,
    input  logic out_toggle,
    input  logic out_level,
    input  logic wrap,
    input  logic eoc,
    output logic pin
);
    logic tog;

    // Follow the fixed level, or invert at each end of count.
    always_ff @(posedge clk) begin
        if (!rst_n)                   tog <= 1'b1;
        else if (!out_en)             tog <= out_level;
        else if (out_toggle && wrap)  tog <= !tog;
    end

    assign pin = !out_en ? out_level : (out_toggle ? tog : eoc);
endmodule

// File: rtl/prescaled_wdog_timer.sv
// Top level: prescaled 16-bit timer with input modes and a watchdog mode.
// Assumes a single clock domain and synchronous ext_in; reads are
// combinational from reg_addr.
module prescaled_wdog_timer
    import pwt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ext_in,
    output logic              eoc_o,
    output logic              irq_o,
    output logic              rst_req_o,
    output logic              tmr_out_o
);
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] reload_nxt;
    logic [REG_W-1:0] pre_val;
    logic             run_eff, wd_en;
    logic             ctrl_single, ctrl_in_en;
    in_mode_e         ctrl_mode;
    logic             out_toggle, out_level, out_en;
    logic             load_req, load_arm;
    logic             single_done, wrap;
    logic             pre_en, pre_restart, tick;

    pwt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .cnt_val    (cnt_val),
        .single_done(single_done),
        .rdata      (reg_rdata),
        .run_eff    (run_eff),
        .wd_en      (wd_en),
        .ctrl_single(ctrl_single),
        .ctrl_mode  (ctrl_mode),
        .ctrl_in_en (ctrl_in_en),
        .out_toggle (out_toggle),
        .out_level  (out_level),
        .out_en     (out_en),
        .pre_val    (pre_val),
        .reload_nxt (reload_nxt),
        .load_req   (load_req),
        .load_arm   (load_arm)
    );

    pwt_prescaler #(.W(REG_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(pre_restart),
        .en     (pre_en),
        .div    (pre_val),
        .tick   (tick)
    );

    pwt_counter u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_eff    (run_eff),
        .wd_en      (wd_en),
        .in_en      (ctrl_in_en),
        .single     (ctrl_single),
        .mode       (ctrl_mode),
        .ext_in     (ext_in),
        .tick       (tick),
        .load_req   (load_req),
        .load_arm   (load_arm),
        .reload_nxt (reload_nxt),
        .cnt        (cnt_val),
        .pre_en     (pre_en),
        .pre_restart(pre_restart),
        .wrap       (wrap),
        .single_done(single_done),
        .eoc        (eoc_o)
    );

    pwt_outpin u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_en    (out_en),
        .out_toggle(out_toggle),
        .out_level (out_level),
        .wrap      (wrap),
        .eoc       (eoc_o),
        .pin       (tmr_out_o)
    );

    assign irq_o     = eoc_o && !wd_en;
    assign rst_req_o = eoc_o && wd_en;
endmodule

// File: rtl/pwt_checker.sv
// Checker for the timer: counter movement, stop hold, end-of-count
// origin, watchdog stickiness and request exclusivity.
// Assumes it is bound into prescaled_wdog_timer.
module pwt_checker
    import pwt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic             run_eff,
    input logic             reload_evt,
    input logic             wd_en,
    input logic             eoc,
    input logic             irq,
    input logic             rst_req
);
    logic ok1, ok2;

    // Mark cycles whose history lies entirely after reset.
    always_ff @(posedge clk) begin
        ok1 <= rst_n;
        ok2 <= ok1 && rst_n;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ok2 && !$past(reload_evt) && $past(cnt) != '0 && cnt != $past(cnt))
            |-> (cnt == $past(cnt) - CNT_W'(1))); // R3

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ok2 && !$past(run_eff) && !$past(reload_evt)) |-> (cnt == $past(cnt))); // R6

    AST_EOC_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ok2 && eoc) |-> ($past(cnt) == '0)); // R4

    AST_WD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wd_en |=> wd_en); // R14

    AST_IRQ_RST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && rst_req)); // R13
endmodule

bind prescaled_wdog_timer pwt_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt_val),
    .run_eff   (run_eff),
    .reload_evt(pre_restart),
    .wd_en     (wd_en),
    .eoc       (eoc_o),
    .irq       (irq_o),
    .rst_req   (rst_req_o)
);

// File: tb/prescaled_wdog_timer_test.sv
// Bench: a period table walked in a loop, then directed mode tests.
module prescaled_wdog_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       ext_in = 1'b0;
    logic       eoc_o, irq_o, rst_req_o, tmr_out_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [47:0] v;
    int          nev;

    localparam logic [2:0] HI = 3'd0, LO = 3'd1, PRE = 3'd2, CTL = 3'd3, WD = 3'd4;

    // {reload[15:0], prescaler[7:0], period[23:0]}, period = (R+1)*(N+1)
    localparam logic [47:0] VECS [5] = '{
        48'h0002_00_000003,
        48'h0001_01_000004,
        48'h0000_00_000001,
        48'h0005_02_000012,
        48'h0010_03_000044
    };

    always #5 clk = ~clk;

    prescaled_wdog_timer uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_in(ext_in),
        .eoc_o(eoc_o), .irq_o(irq_o), .rst_req_o(rst_req_o), .tmr_out_o(tmr_out_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(req, {8'h00, reg_rdata}, {8'h00, exp});
    endtask

    task automatic setup(input logic [15:0] rl, input logic [7:0] pr, input logic [7:0] c);
        wr(CTL, 8'h00);
        wr(HI, rl[15:8]);
        wr(LO, rl[7:0]);
        wr(PRE, pr);
        wr(CTL, c);
    endtask

    task automatic pulse();
        ext_in = 1'b1;
        @(negedge clk);
        ext_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(HI, 8'hFF, "R1 hi"); rd(LO, 8'hFF, "R1 lo"); rd(PRE, 8'hFF, "R1 pre");
        rd(CTL, 8'h12, "R1 ctrl"); rd(WD, 8'h00, "R1 wd");
        chk("R1 pin", tmr_out_o, 1); chk("R1 eoc", eoc_o, 0);
        chk("R1 irq", irq_o, 0); chk("R1 rst", rst_req_o, 0);
        // R2 read-back of prescaler and control while stopped
        wr(PRE, 8'h5A); rd(PRE, 8'h5A, "R2 pre");
        wr(CTL, 8'h4C); rd(CTL, 8'h4C, "R2 ctrl");

        // R3 period table, free counting (triggered mode, input disabled)
        for (int i = 0; i < 5; i++) begin
            v = VECS[i];
            setup(v[47:32], v[31:24], 8'hA0);
            for (int k = 1; k <= int'(v[23:0]); k++) begin
                @(negedge clk);
                chk("R3 eoc", eoc_o, (k == int'(v[23:0])) ? 1 : 0);
                chk("R13 irq", irq_o, (k == int'(v[23:0])) ? 1 : 0);
            end
        end

        // R4 continuous repeats, single stops
        setup(16'd2, 8'd0, 8'hA0);
        nev = 0;
        for (int k = 1; k <= 9; k++) begin @(negedge clk); nev += int'(eoc_o); end
        chk("R4 continuous count", 16'(nev), 3);
        setup(16'd2, 8'd0, 8'hE0);
        nev = 0;
        for (int k = 1; k <= 9; k++) begin @(negedge clk); nev += int'(eoc_o); end
        chk("R4 single count", 16'(nev), 1);
        rd(CTL, 8'h60, "R4 run cleared");

        // R5 live read, reload write does not disturb the count
        setup(16'h0105, 8'd0, 8'hA0);
        repeat (3) @(negedge clk);
        rd(HI, 8'h01, "R5 live hi"); rd(LO, 8'h02, "R5 live lo");
        wr(LO, 8'h00);
        rd(LO, 8'h01, "R5 lo after reload write");
        // R6 stop freezes the count
        wr(CTL, 8'h20);
        repeat (4) @(negedge clk);
        rd(LO, 8'h00, "R6 frozen lo"); rd(HI, 8'h01, "R6 frozen hi");

        // R7 input disabled: gated mode with input low still counts
        setup(16'd3, 8'd0, 8'h90);
        repeat (2) @(negedge clk);
        rd(LO, 8'h01, "R7 ignored input");

        // R9 gated
        setup(16'd3, 8'd0, 8'h98);
        repeat (4) @(negedge clk);
        rd(LO, 8'h03, "R9 gate low holds");
        ext_in = 1'b1;
        repeat (2) @(negedge clk);
        ext_in = 1'b0;
        rd(LO, 8'h01, "R9 gate high counts");
        repeat (2) @(negedge clk);
        rd(LO, 8'h01, "R9 gate low again");

        // R8 event counting, prescaler value irrelevant
        setup(16'd4, 8'd5, 8'h88);
        repeat (3) pulse();
        rd(LO, 8'h01, "R8 three edges");
        ext_in = 1'b1;
        repeat (4) @(negedge clk);
        ext_in = 1'b0;
        @(negedge clk);
        rd(LO, 8'h00, "R8 held level counts once");
        pulse();
        rd(LO, 8'h04, "R8 wrap reload");

        // R10 triggered
        setup(16'd3, 8'd0, 8'hA8);
        repeat (3) @(negedge clk);
        rd(LO, 8'h03, "R10 idle until edge");
        pulse(); rd(LO, 8'h02, "R10 trigger starts");
        pulse(); rd(LO, 8'h00, "R10 edge ignored while counting");

        // R11 retriggered
        setup(16'd3, 8'd0, 8'hB8);
        repeat (3) @(negedge clk);
        rd(LO, 8'h03, "R11 idle until edge");
        pulse(); rd(LO, 8'h02, "R11 first edge");
        pulse(); rd(LO, 8'h02, "R11 edge reloads");

        // R12 output pin
        wr(CTL, 8'h02); chk("R12 level 1", tmr_out_o, 1);
        setup(16'd1, 8'd0, 8'hA5);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            chk("R12 toggle", tmr_out_o, (k == 2 || k == 3) ? 1 : 0);
        end
        wr(CTL, 8'h00); chk("R12 level 0", tmr_out_o, 0);
        setup(16'd1, 8'd0, 8'hA1);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk("R12 pulse", tmr_out_o, (k == 2) ? 1 : 0);
        end
        wr(CTL, 8'hA2);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            chk("R12 disabled holds level", tmr_out_o, 1);
        end

        // R14 watchdog
        setup(16'd9, 8'd0, 8'h08);
        wr(WD, 8'h01);
        rd(CTL, 8'h88, "R14 run forced");
        wr(WD, 8'h00);
        rd(WD, 8'h01, "R14 sticky");
        wr(CTL, 8'h08);
        rd(CTL, 8'h88, "R14 run stays forced");
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                chk("R14 no reset while refreshed", rst_req_o, 0);
            end
            wr(LO, 8'h09);
        end
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            chk("R14 reset request", rst_req_o, (k == 10) ? 1 : 0);
            chk("R14 no irq", irq_o, 0);
        end

        // R1 reset clears watchdog mode
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(WD, 8'h00, "R1 wd after reset");
        rd(CTL, 8'h12, "R1 ctrl after reset");
        finish_run();
    end
endmodule